// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 32 interrupt request lines from surrounding peripherals and drives a single interrupt line to a processor. Every line has a 4-bit priority register and a bit in an enable mask. A global 4-bit threshold sets the level a request must beat. A pending request is eligible only when all three hold: its enable bit is set, its priority is non-zero, and its priority is strictly above the threshold. The output interrupt is high while any eligible request exists.

Software uses a simple register bus to take an interrupt. Reading the claim register returns the identifier of the best eligible request and removes that request from the pending set. The highest priority wins, and on a tie the lowest identifier wins. The source then stays blocked until software writes its identifier back to the same address as a completion notice. Source lines are level sensitive. A line that is still high after completion becomes pending again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is low and every priority, the enable mask, the threshold and the pending set are zero. A claim read returns 0.
- R2: A source whose line is high on a clock edge, and which is not already pending or claimed, becomes pending at that edge. Bit i of the pending word (address 0x23) is the source on `src_i[i]`, which has identifier i+1.
- R3: A source with priority 0 is never chosen and never raises `irq_o`, whatever the threshold or the enable mask holds.
- R4: A pending source whose enable-mask bit (bit i of address 0x20) is 0 is never chosen and never raises `irq_o`.
- R5: A pending, enabled source is eligible only when its priority is strictly greater than the threshold (bits [3:0] of address 0x21). When the two are equal, it is not eligible.
- R6: Among eligible sources, the one with the highest priority is chosen. Among equal priorities, the lowest identifier is chosen.
- R7: A read of address 0x22 returns the chosen identifier (i+1 for `src_i[i]`) on `bus_rdata` in the cycle after the read strobe, and clears that source's pending bit. It returns 0 and changes nothing when no source is eligible.
- R8: A claimed source cannot become pending again until its identifier is written to address 0x22. A completion write that carries any other identifier leaves it blocked.
- R9: `irq_o` is a register. It rises on the clock edge after the one that makes a request eligible, and falls on the edge after the one that leaves no request eligible.
- R10: Addresses 0x00 to 0x1F hold the priority of sources 0 to 31 in bits [3:0]. Address 0x20 holds the enable mask and 0x21 holds the threshold in bits [3:0]. Every one of these reads back the value that was written, with bits above the field width returning 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| src_i | input | 32 | Level-sensitive interrupt request lines, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after `bus_rd` |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
Each result has its own latency, and every check waits exactly that many edges before it samples.

- **Source capture:** a source line seen high at one edge becomes pending at that edge. `irq_o` follows at the next edge, so the bench checks `irq_o` is still low one cycle after it raises a line and high one cycle later.
- **Read data:** register reads return data one edge after the strobe. A claim takes effect at the edge of its own read, so `irq_o` is checked to stay high immediately afterwards and to fall one cycle later.
- **Completion:** a completion write re-arms a source at the edge after it, so a pending read is placed one idle cycle after the write.
- **Sweeps:** the bench sweeps random priorities, masks, thresholds and line patterns. It drains every claim in order and compares each returned identifier against a model computed in the bench.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // Selector of the control word decoded from the low address bits
    // when the address falls in the control half of the map.
    typedef enum logic [1:0] {
        CTL_ENABLE = 2'd0,
        CTL_THRESH = 2'd1,
        CTL_CLAIM  = 2'd2,
        CTL_PEND   = 2'd3
    } ctl_sel_e;

endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 4,
    parameter int DATA_W  = 32,
    parameter int ID_W    = $clog2(NUM_SRC + 1),
    parameter int IDX_W   = $clog2(NUM_SRC),
    parameter int ADDR_W  = IDX_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [ID_W-1:0]                win_id_i,
    input  logic [NUM_SRC-1:0]             pend_i,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
    output logic [NUM_SRC-1:0]             enable_o,
    output logic [PRIO_W-1:0]              thresh_o,
    output logic                           claim_o,
    output logic                           cmpl_valid_o,
    output logic [ID_W-1:0]                cmpl_id_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_SRC-1:0]             enable;
        logic [PRIO_W-1:0]              thresh;
        logic [DATA_W-1:0]              rdata;
    } regs_t;

    regs_t reg_d, reg_q;

    logic             is_ctl;
    ctl_sel_e         sel;
    logic [IDX_W-1:0] idx;
    logic             idx_ok;

    assign is_ctl = bus_addr[ADDR_W-1];
    assign sel    = ctl_sel_e'(bus_addr[1:0]);
    assign idx    = bus_addr[IDX_W-1:0];

    generate
        if (NUM_SRC == (1 << IDX_W)) begin : g_full_map
            assign idx_ok = 1'b1;
        end else begin : g_part_map
            assign idx_ok = ({1'b0, idx} < (IDX_W + 1)'(NUM_SRC));
        end
    endgenerate

    assign claim_o      = bus_rd && is_ctl && (sel == CTL_CLAIM);
    assign cmpl_valid_o = bus_wr && is_ctl && (sel == CTL_CLAIM);
    assign cmpl_id_o    = bus_wdata[ID_W-1:0];

    always_comb begin
        reg_d = reg_q;
        if (bus_wr) begin
            if (is_ctl) begin
                case (sel)
                    CTL_ENABLE: reg_d.enable = bus_wdata[NUM_SRC-1:0];
                    CTL_THRESH: reg_d.thresh = bus_wdata[PRIO_W-1:0];
                    default: ;
                endcase
            end else if (idx_ok) begin
                reg_d.prio[idx] = bus_wdata[PRIO_W-1:0];
            end
        end
        if (bus_rd) begin
            if (is_ctl) begin
                case (sel)
                    CTL_ENABLE: reg_d.rdata = DATA_W'(reg_q.enable);
                    CTL_THRESH: reg_d.rdata = DATA_W'(reg_q.thresh);
                    CTL_CLAIM:  reg_d.rdata = DATA_W'(win_id_i);
                    default:    reg_d.rdata = DATA_W'(pend_i);
                endcase
            end else if (idx_ok) begin
                reg_d.rdata = DATA_W'(reg_q.prio[idx]);
            end else begin
                reg_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign bus_rdata = reg_q.rdata;
    assign prio_o    = reg_q.prio;
    assign enable_o  = reg_q.enable;
    assign thresh_o  = reg_q.thresh;

    // R7
    claim_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |=> (bus_rdata == DATA_W'($past(win_id_i))));

endmodule

// File: rtl/pic_gateway.sv
module pic_gateway #(
    parameter int NUM_SRC = 32,
    parameter int ID_W    = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               claim_i,
    input  logic [ID_W-1:0]    claim_id_i,
    input  logic               cmpl_valid_i,
    input  logic [ID_W-1:0]    cmpl_id_i,
    output logic [NUM_SRC-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] claimed;
    } gw_t;

    gw_t gw_d, gw_q;

    logic [NUM_SRC-1:0] claim_hit;
    logic [NUM_SRC-1:0] cmpl_hit;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
            assign claim_hit[i] = claim_i && (claim_id_i == ID_W'(i + 1));
            assign cmpl_hit[i]  = cmpl_valid_i && (cmpl_id_i == ID_W'(i + 1));
        end
    endgenerate

    always_comb begin
        gw_d         = gw_q;
        gw_d.pend    = (gw_q.pend | (src_i & ~gw_q.claimed)) & ~claim_hit;
        gw_d.claimed = (gw_q.claimed & ~cmpl_hit) | claim_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gw_q <= '0;
        end else begin
            gw_q <= gw_d;
        end
    end

    assign pend_o = gw_q.pend;

    // R8
    pend_claim_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_q.pend & gw_q.claimed) == '0);

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
            // R7
            claim_from_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(gw_q.claimed[i]) |-> $past(gw_q.pend[i]));
            // R8
            release_on_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(gw_q.claimed[i]) |-> $past(cmpl_valid_i && (cmpl_id_i == ID_W'(i + 1))));
        end
    endgenerate

endmodule

// File: rtl/pic_prio_tree.sv
module pic_prio_tree #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 4,
    parameter int ID_W    = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0]             elig_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                           win_valid_o,
    output logic [ID_W-1:0]                win_id_o,
    output logic [PRIO_W-1:0]              win_prio_o
);

    localparam int LVL = $clog2(NUM_SRC);
    localparam int NL  = 1 << LVL;

    // Heap layout: node k has children 2k and 2k+1, leaves at NL..2NL-1.
    logic              node_v  [2*NL];
    logic [PRIO_W-1:0] node_p  [2*NL];
    logic [ID_W-1:0]   node_id [2*NL];

    assign node_v[0]  = 1'b0;
    assign node_p[0]  = '0;
    assign node_id[0] = '0;

    generate
        for (genvar i = 0; i < NL; i++) begin : g_leaf
            if (i < NUM_SRC) begin : g_real
                assign node_v[NL+i]  = elig_i[i];
                assign node_p[NL+i]  = prio_i[i];
                assign node_id[NL+i] = ID_W'(i + 1);
            end else begin : g_pad
                assign node_v[NL+i]  = 1'b0;
                assign node_p[NL+i]  = '0;
                assign node_id[NL+i] = '0;
            end
        end

        for (genvar k = 1; k < NL; k++) begin : g_node
            logic pick_r;
            // Right child wins only on strictly higher priority: ties keep lower id.
            assign pick_r     = node_v[2*k+1] &&
                                (!node_v[2*k] || (node_p[2*k+1] > node_p[2*k]));
            assign node_v[k]  = node_v[2*k] | node_v[2*k+1];
            assign node_p[k]  = pick_r ? node_p[2*k+1]  : node_p[2*k];
            assign node_id[k] = pick_r ? node_id[2*k+1] : node_id[2*k];
        end
    endgenerate

    assign win_valid_o = node_v[1];
    assign win_id_o    = node_v[1] ? node_id[1] : '0;
    assign win_prio_o  = node_p[1];

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 4,
    parameter int DATA_W  = 32,
    parameter int ID_W    = $clog2(NUM_SRC + 1),
    parameter int IDX_W   = $clog2(NUM_SRC),
    parameter int ADDR_W  = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);

    typedef struct packed {
        logic irq;
    } top_t;

    top_t top_d, top_q;

    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic [NUM_SRC-1:0]             enable;
    logic [PRIO_W-1:0]              thresh;
    logic [NUM_SRC-1:0]             pend;
    logic [NUM_SRC-1:0]             elig;
    logic                           claim;
    logic                           cmpl_valid;
    logic [ID_W-1:0]                cmpl_id;
    logic                           win_valid;
    logic [ID_W-1:0]                win_id;
    logic [PRIO_W-1:0]              win_prio;
    logic [ID_W-1:0]                win_m1;

    pic_regs #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
        .ID_W(ID_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .win_id_i     (win_id),
        .pend_i       (pend),
        .prio_o       (prio),
        .enable_o     (enable),
        .thresh_o     (thresh),
        .claim_o      (claim),
        .cmpl_valid_o (cmpl_valid),
        .cmpl_id_o    (cmpl_id)
    );

    pic_gateway #(
        .NUM_SRC(NUM_SRC), .ID_W(ID_W)
    ) u_gateway (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src_i),
        .claim_i      (claim),
        .claim_id_i   (win_id),
        .cmpl_valid_i (cmpl_valid),
        .cmpl_id_i    (cmpl_id),
        .pend_o       (pend)
    );

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
            assign elig[i] = pend[i] & enable[i] & (prio[i] > thresh);
        end
    endgenerate

    pic_prio_tree #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
    ) u_tree (
        .elig_i      (elig),
        .prio_i      (prio),
        .win_valid_o (win_valid),
        .win_id_o    (win_id),
        .win_prio_o  (win_prio)
    );

    always_comb begin
        top_d     = top_q;
        top_d.irq = |elig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign irq_o  = top_q.irq;
    assign win_m1 = win_id - ID_W'(1);

    // R5
    winner_above_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_prio > thresh));

    // R4
    winner_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (enable[win_m1[IDX_W-1:0]] && pend[win_m1[IDX_W-1:0]]));

    // R9
    irq_follows_tree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(win_valid));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_i;
    logic        bus_wr;
    logic        bus_rd;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    localparam logic [5:0] A_ENABLE = 6'h20;
    localparam logic [5:0] A_THRESH = 6'h21;
    localparam logic [5:0] A_CLAIM  = 6'h22;
    localparam logic [5:0] A_PEND   = 6'h23;

    always #4 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // Bench model of the configuration
    logic [3:0]  mp [32];
    logic [31:0] men;
    logic [3:0]  mth;
    logic [31:0] mpend;
    logic [31:0] lfsr;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_rd   = 1'b1;
        bus_addr = a;
        tick();
        d        = bus_rdata;
        bus_rd   = 1'b0;
    endtask

    function automatic logic [31:0] xs(input logic [31:0] v);
        logic [31:0] x;
        x = v;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic int model_winner();
        int best;
        best = 0;
        for (int j = 0; j < 32; j++) begin
            if (mpend[j] && men[j] && (mp[j] > mth) &&
                (best == 0 || mp[j] > mp[best-1]))
                best = j + 1;
        end
        return best;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] pat;
        int          w;
        rst_n     = 1'b0;
        src_i     = '0;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        check("R1 irq", 32'(irq_o), 32'd0);
        rd(A_ENABLE, d); check("R1 enable", d, 32'd0);
        rd(A_THRESH, d); check("R1 thresh", d, 32'd0);
        rd(A_PEND, d);   check("R1 pending", d, 32'd0);
        rd(6'd7, d);     check("R1 prio7", d, 32'd0);
        rd(A_CLAIM, d);  check("R1 claim", d, 32'd0);

        // R10: register readback over the whole map
        for (int i = 0; i < 32; i++) wr(6'(i), 32'hFFFF_FFF0 | 32'((i * 5 + 2) & 15));
        for (int i = 0; i < 32; i++) begin
            rd(6'(i), d);
            check("R10 prio readback", d, 32'((i * 5 + 2) & 15));
        end
        wr(A_THRESH, 32'hFFFF_FFF9);
        rd(A_THRESH, d); check("R10 thresh readback", d, 32'd9);
        wr(A_ENABLE, 32'hA5A5_0F0F);
        rd(A_ENABLE, d); check("R10 enable readback", d, 32'hA5A5_0F0F);

        // R9: irq latency; source 9 (id 10) has priority 15
        wr(A_THRESH, 32'd0);
        wr(A_ENABLE, 32'hFFFF_FFFF);
        src_i = 32'h0000_0200;
        tick();
        check("R9 irq not yet", 32'(irq_o), 32'd0);
        tick();
        check("R9 irq raised", 32'(irq_o), 32'd1);
        src_i = '0;
        rd(A_CLAIM, d);
        check("R7 claim id10", d, 32'd10);
        check("R9 irq held one cycle", 32'(irq_o), 32'd1);
        tick();
        check("R9 irq dropped", 32'(irq_o), 32'd0);
        wr(A_CLAIM, 32'd10);

        // R8: claimed source held high stays blocked until completed (id 5, prio 6)
        src_i = 32'h0000_0010;
        tick(); tick();
        rd(A_CLAIM, d);  check("R8 claim id5", d, 32'd5);
        tick();
        rd(A_PEND, d);   check("R8 blocked after claim", d, 32'd0);
        wr(A_CLAIM, 32'd6);
        tick();
        rd(A_PEND, d);   check("R8 wrong complete ignored", d, 32'd0);
        wr(A_CLAIM, 32'd5);
        tick();
        rd(A_PEND, d);   check("R8 re-pend after complete", d, 32'h0000_0010);
        src_i = '0;
        rd(A_CLAIM, d);  check("R8 reclaim id5", d, 32'd5);
        wr(A_CLAIM, 32'd5);
        tick();

        // Sweep: R2 R3 R4 R5 R6 R7 R9 over pseudo-random configurations
        lfsr = 32'h1234_5678;
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < 32; i++) begin
                lfsr  = xs(lfsr);
                mp[i] = (t % 4 == 1) ? 4'(4 + (i & 1)) : lfsr[3:0];
                wr(6'(i), 32'(mp[i]));
            end
            lfsr = xs(lfsr);
            men  = (t % 5 == 2) ? 32'hFFFF_FFFF : lfsr;
            lfsr = xs(lfsr);
            mth  = (t == 0) ? 4'd15 : ((t == 1) ? 4'd0 : {1'b0, lfsr[2:0]});
            lfsr = xs(lfsr);
            pat  = lfsr;
            wr(A_ENABLE, men);
            wr(A_THRESH, 32'(mth));
            src_i = pat;
            tick();
            src_i = '0;
            tick();
            mpend = pat;
            // R3 R4 R5 R9: irq reflects any eligible source
            check("R9/R3/R4/R5 irq level", 32'(irq_o), 32'(model_winner() != 0));
            rd(A_PEND, d);
            check("R2 pending capture", d, pat);
            for (int k = 0; k < 33; k++) begin
                w = model_winner();
                rd(A_CLAIM, d);
                check("R6/R7 claim order", d, 32'(w));
                if (w == 0) break;
                mpend[w-1] = 1'b0;
            end
            check("R9 irq after drain", 32'(irq_o), 32'd0);
            // Drain everything left (priority 0, masked, below threshold)
            wr(A_ENABLE, 32'hFFFF_FFFF);
            wr(A_THRESH, 32'd0);
            for (int i = 0; i < 32; i++) wr(6'(i), 32'd15);
            for (int k = 0; k < 33; k++) begin
                rd(A_CLAIM, d);
                if (d == 0) break;
            end
            for (int i = 1; i <= 32; i++) wr(A_CLAIM, 32'(i));
            tick();
        end

        summary();
        $finish;
    end

endmodule